// File: doc/BRIEF.md
# Trap Condition Evaluator

This block recognises the four conditional trap instructions of a 32-bit fixed-length instruction set and decides whether each one should raise a trap. It handles an immediate form and a register form, each in a 32-bit word width and a 64-bit doubleword width. Each cycle it accepts an instruction word with a valid strobe. It drives the two source register indices to a 64-bit register-file read port and takes the two operands back in the same cycle.

The operands are compared signed and unsigned. The five comparison results are masked by the instruction's 5-bit condition field and ORed together. A registered one-cycle trap pulse and a registered "trap instruction seen" flag appear on the clock edge after the instruction is presented. Any encoding that is not one of the four trap forms is reported as not-a-trap.

Top module: `trap_unit`

## Requirements
- R1: Opcode field instr[31:26]=3 is word-immediate and =2 is doubleword-immediate. Opcode 31 with instr[10:1]=4 is word-register, and opcode 31 with instr[10:1]=68 is doubleword-register. Every other encoding drives neither is_trap_o nor trap_o.
- R2: In the word forms, each register operand is its low 32 bits sign-extended to 64 bits, so the upper 32 register bits never affect the result.
- R3: In the immediate forms, operand b is instr[15:0] sign-extended to 64 bits.
- R4: The condition field is instr[25:21]. instr[25] enables signed a<b, instr[24] signed a>b, instr[23] a==b, instr[22] unsigned a<b and instr[21] unsigned a>b. A trap fires when any enabled condition holds.
- R5: trap_o and is_trap_o are registered. They are high only in the single cycle after a valid trap instruction, even when several conditions hold at once.
- R6: A zero condition field never traps. An all-ones condition field always traps.
- R7: The doubleword forms compare the full 64-bit register values.
- R8: While rst_ni is low, trap_o and is_trap_o are 0 whatever the inputs.
- R9: rs_a_idx_o is instr[20:16] and rs_b_idx_o is instr[15:11].
- R10: instr[0] has no effect on the register forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| rs_a_idx_o | output | 5 | Register-file read index for operand a |
| rs_b_idx_o | output | 5 | Register-file read index for operand b |
| rs_a_data_i | input | 64 | Register value read at rs_a_idx_o |
| rs_b_data_i | input | 64 | Register value read at rs_b_idx_o |
| trap_o | output | 1 | One-cycle trap pulse |
| is_trap_o | output | 1 | Previous cycle carried a valid trap instruction |

## Verification
The assertions assume that the register-file data answers the indices combinationally within the same cycle. They also assume that valid_i and instr_i stay stable around the sampling edge. The bench models the register file as an array indexed by the block's own index outputs. It changes inputs only shortly after a rising edge. It holds valid_i low through reset, except for one deliberate case that checks reset dominance, and the outputs stay 0 there by construction of the reset.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int ILEN  = 32;
  localparam int IMM_W = 16;
  localparam int IDX_W = 5;
  localparam int CND_W = 5;

  localparam logic [5:0] OPC_WIMM = 6'd3;
  localparam logic [5:0] OPC_DIMM = 6'd2;
  localparam logic [5:0] OPC_EXT  = 6'd31;
  localparam logic [9:0] XO_WREG  = 10'd4;
  localparam logic [9:0] XO_DREG  = 10'd68;

  typedef enum logic [2:0] {
    FORM_NONE,
    FORM_WIMM,
    FORM_DIMM,
    FORM_WREG,
    FORM_DREG
  } trap_form_e;

  typedef struct packed {
    trap_form_e            form;
    logic [CND_W-1:0]      cond_mask;
    logic [IDX_W-1:0]      ra;
    logic [IDX_W-1:0]      rb;
    logic [IMM_W-1:0]      imm;
    logic                  use_imm;
    logic                  word;
    logic                  is_trap;
  } trap_dec_t;
endpackage

// File: rtl/trap_decode.sv
module trap_decode
  import trap_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ILEN-1:0] instr_i,
  output trap_dec_t       dec_o
);
  logic [5:0] opc;
  logic [9:0] xo;

  assign opc = instr_i[31:26];
  assign xo  = instr_i[10:1];

  always_comb begin
    dec_o.form = FORM_NONE;
    if (opc == OPC_WIMM)                        dec_o.form = FORM_WIMM;
    else if (opc == OPC_DIMM)                   dec_o.form = FORM_DIMM;
    else if (opc == OPC_EXT && xo == XO_WREG)   dec_o.form = FORM_WREG;
    else if (opc == OPC_EXT && xo == XO_DREG)   dec_o.form = FORM_DREG;
    dec_o.cond_mask = instr_i[25:21];
    dec_o.ra        = instr_i[20:16];
    dec_o.rb        = instr_i[15:11];
    dec_o.imm       = instr_i[IMM_W-1:0];
    dec_o.use_imm   = (dec_o.form == FORM_WIMM) || (dec_o.form == FORM_DIMM);
    dec_o.word      = (dec_o.form == FORM_WIMM) || (dec_o.form == FORM_WREG);
    dec_o.is_trap   = (dec_o.form != FORM_NONE);
  end

  // decoding an unknown primary opcode never yields a trap form
  assert_unknown_opc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opc != OPC_WIMM && opc != OPC_DIMM && opc != OPC_EXT) |-> !dec_o.is_trap);

  assert_imm_has_no_rb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_o.use_imm |-> (opc != OPC_EXT));
endmodule

// File: rtl/trap_operands.sv
module trap_operands
  import trap_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [XLEN-1:0]  rs_a_i,
  input  logic [XLEN-1:0]  rs_b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             word_i,
  output logic [XLEN-1:0]  op_a_o,
  output logic [XLEN-1:0]  op_b_o
);
  localparam int WEXT = XLEN - WLEN;
  localparam int IEXT = XLEN - IMM_W;

  logic [XLEN-1:0] a_w, b_w, imm_x;

  assign a_w   = {{WEXT{rs_a_i[WLEN-1]}}, rs_a_i[WLEN-1:0]};
  assign b_w   = {{WEXT{rs_b_i[WLEN-1]}}, rs_b_i[WLEN-1:0]};
  assign imm_x = {{IEXT{imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    op_a_o = word_i ? a_w : rs_a_i;
    if (use_imm_i)   op_b_o = imm_x;
    else if (word_i) op_b_o = b_w;
    else             op_b_o = rs_b_i;
  end

  assert_word_sext_a_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_i |-> (op_a_o[XLEN-1:WLEN-1] == '0 || op_a_o[XLEN-1:WLEN-1] == '1));

  assert_imm_sext_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_imm_i |-> (op_b_o[XLEN-1:IMM_W-1] == '0 || op_b_o[XLEN-1:IMM_W-1] == '1));
endmodule

// File: rtl/trap_compare.sv
module trap_compare
  import trap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [XLEN-1:0]  op_a_i,
  input  logic [XLEN-1:0]  op_b_i,
  input  logic [CND_W-1:0] mask_i,
  output logic             hit_o
);
  // condition vector ordered to match mask bits, MSB first: slt sgt eq ult ugt
  logic [CND_W-1:0] cond;

  always_comb begin
    cond[4] = $signed(op_a_i) < $signed(op_b_i);
    cond[3] = $signed(op_a_i) > $signed(op_b_i);
    cond[2] = op_a_i == op_b_i;
    cond[1] = op_a_i < op_b_i;
    cond[0] = op_a_i > op_b_i;
  end

  assign hit_o = |(cond & mask_i);

  assert_zero_mask_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !hit_o);

  assert_full_mask_fires_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> hit_o);

  assert_signed_trichotomy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cond[4:2]) == 1);
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  output logic [4:0]      rs_a_idx_o,
  output logic [4:0]      rs_b_idx_o,
  input  logic [XLEN-1:0] rs_a_data_i,
  input  logic [XLEN-1:0] rs_b_data_i,
  output logic            trap_o,
  output logic            is_trap_o
);
  trap_dec_t       dec;
  logic [XLEN-1:0] op_a, op_b;
  logic            hit;

  trap_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  assign rs_a_idx_o = dec.ra;
  assign rs_b_idx_o = dec.rb;

  trap_operands #(.XLEN(XLEN), .WLEN(WLEN)) u_ops (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rs_a_i    (rs_a_data_i),
    .rs_b_i    (rs_b_data_i),
    .imm_i     (dec.imm),
    .use_imm_i (dec.use_imm),
    .word_i    (dec.word),
    .op_a_o    (op_a),
    .op_b_o    (op_b)
  );

  trap_compare #(.XLEN(XLEN)) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_a_i (op_a),
    .op_b_i (op_b),
    .mask_i (dec.cond_mask),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o    <= 1'b0;
      is_trap_o <= 1'b0;
    end else begin
      is_trap_o <= valid_i && dec.is_trap;
      trap_o    <= valid_i && dec.is_trap && hit;
    end
  end

  assert_trap_needs_inst_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> is_trap_o);

  assert_pulse_after_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !trap_o && !is_trap_o);

  assert_idle_reset_R8: assert property (@(posedge clk_i)
    !rst_ni |-> !trap_o && !is_trap_o);
endmodule

// File: tb/sim_trap_unit.sv
`timescale 1ns/1ps
module sim_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [4:0]  a_idx, b_idx;
  logic [63:0] a_data, b_data;
  logic        trap, is_trap;

  logic [63:0] rf [32];
  int checks = 0, errors = 0;
  bit done = 0, started = 0;
  string tag = "R8";

  always #2.5 clk = ~clk;

  assign a_data = rf[a_idx];
  assign b_data = rf[b_idx];

  trap_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .rs_a_idx_o(a_idx), .rs_b_idx_o(b_idx),
    .rs_a_data_i(a_data), .rs_b_data_i(b_data),
    .trap_o(trap), .is_trap_o(is_trap)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_imm(input int op, input int cm, input int ra, input int imm);
    return {6'(op), 5'(cm), 5'(ra), 16'(imm)};
  endfunction

  function automatic logic [31:0] mk_reg(input int xo, input int cm, input int ra, input int rb,
                                         input bit lsb);
    return {6'd31, 5'(cm), 5'(ra), 5'(rb), 10'(xo), lsb};
  endfunction

  // behavioural reference
  function automatic void ref_eval(input logic [31:0] ins, output bit it, output bit tr);
    int op = int'(ins[31:26]);
    int xo = int'(ins[10:1]);
    bit word, imm;
    longint a, b;
    longint unsigned ua, ub;
    logic [4:0] m = ins[25:21];
    it = 0; tr = 0; word = 0; imm = 0;
    if (op == 3) begin it = 1; word = 1; imm = 1; end
    else if (op == 2) begin it = 1; imm = 1; end
    else if (op == 31 && xo == 4) begin it = 1; word = 1; end
    else if (op == 31 && xo == 68) it = 1;
    if (!it) return;
    a = word ? longint'($signed(rf[ins[20:16]][31:0])) : longint'(rf[ins[20:16]]);
    if (imm) b = longint'($signed(ins[15:0]));
    else b = word ? longint'($signed(rf[ins[15:11]][31:0])) : longint'(rf[ins[15:11]]);
    ua = a; ub = b;
    tr = (m[4] && a < b) || (m[3] && a > b) || (m[2] && a == b) ||
         (m[1] && ua < ub) || (m[0] && ua > ub);
  endfunction

  logic  exp_trap = 0, exp_is = 0;
  string exp_tag = "R8";

  always @(posedge clk) begin
    bit it, tr;
    started <= 1;
    if (!rst_n) begin
      exp_trap <= 0; exp_is <= 0; exp_tag <= "R8";
    end else begin
      ref_eval(instr, it, tr);
      exp_is   <= valid & it;
      exp_trap <= valid & it & tr;
      exp_tag  <= tag;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(trap === exp_trap, exp_tag, "trap_o", 64'(trap), 64'(exp_trap));
      chk(is_trap === exp_is, exp_tag, "is_trap_o", 64'(is_trap), 64'(exp_is));
    end
  end

  task automatic issue(input logic [31:0] ins, input string t);
    @(posedge clk); #1;
    instr = ins; valid = 1; tag = t;
    #0.5;
    chk(a_idx == ins[20:16], "R9", "rs_a_idx_o", 64'(a_idx), 64'(ins[20:16]));
    chk(b_idx == ins[15:11], "R9", "rs_b_idx_o", 64'(b_idx), 64'(ins[15:11]));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      valid = 0; tag = "R5";
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 64'(i);
    rf[1] = '1;
    rf[2] = 64'd1;
    rf[3] = 64'h12345678_00000005;
    rf[4] = 64'hABCDEF00_00000005;
    rf[5] = 64'd5;
    rf[6] = 64'h00000000_80000000;
    rf[7] = 64'h00000000_7FFFFFFF;
    rf[0] = '0;

    // R8: valid all-ones trap under reset must stay silent
    valid = 1; instr = mk_reg(4, 31, 1, 2, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(trap === 0 && is_trap === 0, "R8", "outputs under reset",
        64'({trap, is_trap}), 64'(0));
    valid = 0; rst_n = 1;
    idle(2);

    // R4: signed vs unsigned disagreement, a=-1 b=1
    issue(mk_reg(4, 5'b10000, 1, 2, 0), "R4");
    issue(mk_reg(4, 5'b01000, 1, 2, 0), "R4");
    issue(mk_reg(4, 5'b00010, 1, 2, 0), "R4");
    issue(mk_reg(4, 5'b00001, 1, 2, 0), "R4");
    issue(mk_reg(68, 5'b00100, 2, 2, 0), "R4");
    idle(1);

    // R2 / R7: equal low words, different upper words
    issue(mk_reg(4, 5'b00100, 3, 4, 0), "R2");
    issue(mk_reg(68, 5'b00100, 3, 4, 0), "R7");
    issue(mk_reg(68, 5'b00001, 4, 3, 0), "R7");
    issue(mk_reg(68, 5'b10000, 4, 3, 0), "R7");
    issue(mk_reg(4, 5'b10000, 6, 7, 0), "R2");
    issue(mk_reg(68, 5'b10000, 6, 7, 0), "R7");
    idle(1);

    // R3: immediate with top bit set
    issue(mk_imm(3, 5'b01000, 5, 16'hFFFF), "R3");
    issue(mk_imm(3, 5'b00010, 5, 16'hFFFF), "R3");
    issue(mk_imm(3, 5'b00001, 5, 16'hFFFF), "R3");
    issue(mk_imm(2, 5'b01000, 0, 16'h8000), "R3");
    issue(mk_imm(2, 5'b00100, 1, 16'hFFFF), "R3");
    issue(mk_imm(3, 5'b00100, 6, 16'h8000), "R3");
    idle(1);

    // R6: mask extremes
    issue(mk_reg(4, 0, 1, 2, 0), "R6");
    issue(mk_imm(2, 0, 5, 5), "R6");
    issue(mk_reg(68, 31, 3, 4, 0), "R6");
    issue(mk_imm(3, 31, 5, 5), "R6");
    idle(1);

    // R5: several conditions at once, single pulse then low
    issue(mk_reg(4, 5'b10010, 1, 2, 0), "R5");
    idle(2);

    // R10: low bit ignored on register forms
    issue(mk_reg(4, 5'b00001, 1, 2, 1), "R10");
    issue(mk_reg(68, 5'b00100, 3, 3, 1), "R10");
    idle(1);

    // R1: non-trap encodings
    issue(mk_reg(5, 31, 1, 2, 0), "R1");
    issue(mk_reg(69, 31, 1, 2, 0), "R1");
    issue(mk_imm(4, 31, 1, 0), "R1");
    issue(mk_imm(30, 31, 1, 0), "R1");
    issue(mk_imm(3, 5'b00100, 5, 5), "R1");
    idle(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R5 watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule